// File: doc/BRIEF.md
# Programmable Parallel Port (Basic Mode)

This block is a programmable parallel interface with three 8-bit ports: A, B and C. Port C is handled as two independent 4-bit sections. The upper nibble goes with port A and the lower nibble goes with port B. A host reaches the block through a synchronous register bus. That bus has an active-low chip select, separate read and write strobes, a 2-bit register select and an 8-bit data path.

A command write sets each of the four sections (A, B, upper C, lower C) to input or output. Output sections drive a latched value. Input sections are read live from their pins at the moment of the read. Pin direction comes out as per-bit output-enable vectors, so the pad ring can build the tristate drivers. Register accesses are single-cycle register transfers with no data stream, so the bus is kept as plain control pins. There is no valid/ready handshake and no back-pressure: every qualified strobe is accepted on the edge where it is sampled.

The register select encoding is fixed:

| Select | Target |
|--------|--------|
| 00 | port A |
| 01 | port B |
| 10 | port C |
| 11 | write-only command register |

When the block sits at four even I/O addresses, address bits 2 and 1 feed the select.

Top module: `ppio_top`

## Requirements
- R1: After reset, all four sections are inputs. Every output-enable bit is 0, every output latch is 0 and `rd_data` is 0.
- R2: Strobes count only while `cs_n` is 0. With `cs_n` high, no latch, direction or `rd_data` changes.
- R3: A write with select 00 loads the port A latch and a write with select 01 loads the port B latch. A write with select 10 loads both nibbles of the port C latch. The new value is on `pa_out`/`pb_out`/`pc_out` in the cycle after the write edge.
- R4: A command write is valid when all of the following hold: bit 7 is 1, and bits 6, 5 and 2 are 0. A valid command sets the directions, where 1 means input. Bit 4 is port A, bit 3 is upper C, bit 1 is port B and bit 0 is lower C. An output section has all its output-enable bits at 1 from the next cycle; an input section has them all at 0.
- R5: A command write with bit 7 at 0, or with any of bits 6, 5 or 2 at 1, is ignored: directions and latches keep their values.
- R6: A valid command write clears every output latch to 0.
- R7: A read updates `rd_data` on its edge, and `rd_data` holds otherwise. A read of port A or port B returns the latch if the section is an output. If the section is an input, it returns the pin value sampled on that edge.
- R8: A read of port C merges the two nibbles independently. Each nibble is the latch if that section is an output and the live pins if it is an input.
- R9: A read with select 11 returns 0.
- R10: A write to an input section updates its latch, so the value is visible on the `*_out` port, while its output enables stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| sel | input | 2 | Register select (00 A, 01 B, 10 C, 11 command) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
All 256 command bytes are written over a known all-output state with nonzero latches. This separates valid mode sets, which change direction and clear the latches, from rejected words, which must leave both untouched. For each of the 16 direction combinations, distinct data is written to each port and distinct values are placed on the pins. Reading back then tells latched data from live pins in each section, and shows whether the two port C nibbles follow their own directions. Separate patterns probe deselected strobes, reads at the command select, and writes into input sections.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CMD = 2'b11
  } sel_e;

  // 1 = section is an input
  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } dir_t;

  localparam dir_t DIR_RESET = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};

  function automatic logic cmd_ok(input logic [7:0] w);
    return w[7] && (w[6:5] == 2'b00) && !w[2];
  endfunction

  function automatic dir_t cmd_dir(input logic [7:0] w);
    dir_t d;
    d.a_in  = w[4];
    d.cu_in = w[3];
    d.b_in  = w[1];
    d.cl_in = w[0];
    return d;
  endfunction
endpackage

// File: rtl/ppio_cmd.sv
module ppio_cmd
  import ppio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_word,
  output dir_t       dir,
  output logic       clr_all
);
  assign clr_all = cmd_we && cmd_ok(cmd_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir <= DIR_RESET;
    else if (clr_all) dir <= cmd_dir(cmd_word);
  end

  // R5
  bad_cmd_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !cmd_ok(cmd_word)) |=> $stable(dir));

  // R4
  good_cmd_sets_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_word[7] && cmd_word[6:5] == 2'b00 && !cmd_word[2])
      |=> (dir.a_in == $past(cmd_word[4])) && (dir.b_in == $past(cmd_word[1])));
endmodule

// File: rtl/ppio_section.sv
module ppio_section #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         clr,
  input  logic [W-1:0] wd,
  input  logic         is_in,
  input  logic [W-1:0] pin,
  output logic [W-1:0] q,
  output logic [W-1:0] oe,
  output logic [W-1:0] rd_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (we)  q <= wd;
  end

  assign oe     = {W{~is_in}};
  assign rd_val = is_in ? pin : q;

  // R3 R10
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (q == $past(wd)));

  // R6
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
endmodule

// File: rtl/ppio_top.sv
module ppio_top
  import ppio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        sel,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] rd_data,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  localparam int NIB_W = PORT_W / 2;

  logic wr_hit, rd_hit, clr_all;
  dir_t dir;

  assign wr_hit = !cs_n && wr_en;
  assign rd_hit = !cs_n && rd_en;

  ppio_cmd u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_we  (wr_hit && sel == SEL_CMD),
    .cmd_word(wr_data[7:0]),
    .dir     (dir),
    .clr_all (clr_all)
  );

  // full-width ports: index 0 = A, 1 = B
  logic [PORT_W-1:0] p_pin [2];
  logic [PORT_W-1:0] p_q   [2];
  logic [PORT_W-1:0] p_oe  [2];
  logic [PORT_W-1:0] p_rd  [2];
  logic              p_in  [2];
  logic              p_we  [2];

  assign p_pin[0] = pa_in;
  assign p_pin[1] = pb_in;
  assign p_in[0]  = dir.a_in;
  assign p_in[1]  = dir.b_in;
  assign p_we[0]  = wr_hit && sel == SEL_A;
  assign p_we[1]  = wr_hit && sel == SEL_B;

  for (genvar g = 0; g < 2; g++) begin : g_port
    ppio_section #(.W(PORT_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .we(p_we[g]), .clr(clr_all),
      .wd(wr_data), .is_in(p_in[g]), .pin(p_pin[g]),
      .q(p_q[g]), .oe(p_oe[g]), .rd_val(p_rd[g])
    );
  end

  assign pa_out = p_q[0];
  assign pb_out = p_q[1];
  assign pa_oe  = p_oe[0];
  assign pb_oe  = p_oe[1];

  // port C nibbles: index 0 = lower, 1 = upper
  logic              n_in [2];
  logic              c_we;
  logic [PORT_W-1:0] c_rd;

  assign n_in[0] = dir.cl_in;
  assign n_in[1] = dir.cu_in;
  assign c_we    = wr_hit && sel == SEL_C;

  for (genvar h = 0; h < 2; h++) begin : g_nib
    ppio_section #(.W(NIB_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .we(c_we), .clr(clr_all),
      .wd(wr_data[h*NIB_W +: NIB_W]), .is_in(n_in[h]),
      .pin(pc_in[h*NIB_W +: NIB_W]),
      .q(pc_out[h*NIB_W +: NIB_W]), .oe(pc_oe[h*NIB_W +: NIB_W]),
      .rd_val(c_rd[h*NIB_W +: NIB_W])
    );
  end

  logic [PORT_W-1:0] rd_mux;
  always_comb begin
    unique case (sel)
      SEL_A:   rd_mux = p_rd[0];
      SEL_B:   rd_mux = p_rd[1];
      SEL_C:   rd_mux = c_rd;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_hit) rd_data <= rd_mux;
  end

  // R2
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)
              && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(rd_data)));

  // R9
  cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && sel == 2'b11) |=> (rd_data == '0));

  // R7
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(rd_data));

  // R4
  oe_section_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pa_oe[0]) |-> (pa_oe == '1));
endmodule

// File: tb/test_ppio_top.sv
`timescale 1ns/1ps
module test_ppio_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ppio_top i_ppio_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en), .rd_en(rd_en),
    .sel(sel), .wr_data(wr_data), .rd_data(rd_data),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [7:0] d, input logic cs = 1'b1);
    @(negedge clk);
    cs_n = !cs; wr_en = 1'b1; sel = s; wr_data = d;
    @(negedge clk);
    cs_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] s, output logic [7:0] d, input logic cs = 1'b1);
    @(negedge clk);
    cs_n = !cs; rd_en = 1'b1; sel = s;
    @(negedge clk);
    d = rd_data;
    cs_n = 1'b1; rd_en = 1'b0;
  endtask

  function automatic logic [7:0] mk_cmd(input logic a, cu, b, cl);
    return {1'b1, 2'b00, a, cu, 1'b0, b, cl};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r, exp_c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", {pa_oe, pb_oe, pc_oe}, 24'h0);
    check("R1 latch", {pa_out, pb_out, pc_out}, 24'h0);
    check("R1 rdata", rd_data, 8'h00);

    // R10 write to input section: latch moves, oe stays low
    bus_write(2'b00, 8'h3C);
    check("R10 latch", pa_out, 8'h3C);
    check("R10 oe", pa_oe, 8'h00);
    pa_in = 8'hC1;
    bus_read(2'b00, r);
    check("R7 live read of input A", r, 8'hC1);

    // R5/R4/R6 sweep over every command byte
    for (int v = 0; v < 256; v++) begin
      logic [7:0] c;
      logic ok;
      c = 8'(v);
      ok = c[7] && c[6:5] == 2'b00 && !c[2];
      bus_write(2'b11, 8'h80);
      bus_write(2'b00, 8'h5A);
      bus_write(2'b10, 8'hA7);
      bus_write(2'b11, c);
      if (ok) begin
        check("R4 pa_oe", pa_oe, {8{~c[4]}});
        check("R4 pb_oe", pb_oe, {8{~c[1]}});
        check("R4 pc_oe", pc_oe, {{4{~c[3]}}, {4{~c[0]}}});
        check("R6 cleared", {pa_out, pc_out}, 16'h0);
      end else begin
        check("R5 oe kept", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);
        check("R5 latch kept", {pa_out, pc_out}, 16'h5AA7);
      end
    end

    // R3/R7/R8 sweep over all 16 direction sets
    for (int k = 0; k < 16; k++) begin
      logic a, cu, b, cl;
      logic [7:0] da, db, dc;
      {a, cu, b, cl} = 4'(k);
      bus_write(2'b11, mk_cmd(a, cu, b, cl));
      da = 8'(k * 17 + 3); db = 8'(~(k * 29)); dc = 8'(k * 45 + 9);
      bus_write(2'b00, da);
      bus_write(2'b01, db);
      bus_write(2'b10, dc);
      check("R3 A latch", pa_out, da);
      check("R3 B latch", pb_out, db);
      check("R3 C latch", pc_out, dc);
      pa_in = 8'(k * 7 + 100); pb_in = 8'(k * 11 + 50); pc_in = 8'(~(k * 13));
      bus_read(2'b00, r);
      check("R7 read A", r, a ? pa_in : da);
      bus_read(2'b01, r);
      check("R7 read B", r, b ? pb_in : db);
      exp_c = {cu ? pc_in[7:4] : dc[7:4], cl ? pc_in[3:0] : dc[3:0]};
      bus_read(2'b10, r);
      check("R8 read C merge", r, exp_c);
      bus_read(2'b11, r);
      check("R9 read cmd", r, 8'h00);
    end

    // R2 deselected strobes
    bus_write(2'b11, mk_cmd(1'b0, 1'b0, 1'b0, 1'b0));
    bus_write(2'b00, 8'h11);
    bus_read(2'b00, r);
    bus_write(2'b00, 8'hEE, 1'b0);
    check("R2 write ignored", pa_out, 8'h11);
    bus_write(2'b11, 8'h9B, 1'b0);
    check("R2 cmd ignored", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);
    bus_read(2'b01, r, 1'b0);
    check("R2 read ignored", rd_data, 8'h11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule